// File: doc/BRIEF.md
# DMA transfer-count interrupt controller

This block watches the two byte counters of a bus-master DMA engine, one for reads and one for writes, and drives a single active-low interrupt line. Software loads each counter through the register port. Each successful transfer in a direction takes its byte count off that direction's counter. When an enabled counter reaches zero, the block sets a sticky status bit and pulls the interrupt low. A master abort or a target abort on the bus also sets a sticky bit and pulls the line low, but only while at least one count interrupt is enabled.

The control/status word holds the two enable bits and the four status bits. Software reads it to find the source of an interrupt. Writing a one to a status bit clears that bit. The line goes high again only when no status bit is pending. A counter-off mode flag stops the counters from raising status, for engines that run without transfer counts.

Top module: `dma_cnt_irq`

## Requirements
- R1: After reset both counters read 0, the control/status word reads 0, and `irq_no` is 1.
- R2: A write to offset 0x30 loads the read counter and a write to offset 0x34 loads the write counter. Reads at the same offsets return the current counter values.
- R3: A pulse on `rd_done_i` or `wr_done_i` subtracts the presented byte count from the counter of that direction. The counter saturates at 0 and never wraps.
- R4: The control/status word sits at offset 0x38. Bit 14 enables the write-count interrupt and bit 15 enables the read-count interrupt. When the write counter steps to 0 with bit 14 set, status bit 18 sets. When the read counter steps to 0 with bit 15 set, status bit 19 sets.
- R5: The zero event fires only on the step from a nonzero value to 0. A further transfer while the counter is already 0 does not set status again.
- R6: A `mabort_i` pulse sets status bit 20 and a `tabort_i` pulse sets status bit 21, but only while bit 14 or bit 15 is set. When both enables are clear, an abort pulse leaves the word unchanged.
- R7: Writing 1 to any of bits 18 to 21 clears that bit. Writing 0 to a status bit leaves it unchanged.
- R8: `irq_no` is 0 while any of bits 18 to 21 is set, and it returns to 1 only after all of them are cleared.
- R9: While `cnt_off_i` is 1, a counter that reaches 0 does not set bit 18 or bit 19.
- R10: If a clear write and a set event hit the same status bit in the same cycle, the bit ends up set.
- R11: All bits of the control/status word other than 14, 15 and 18 to 21 read as 0, and writes to them have no effect.
- R12: A counter that reaches 0 while its own enable bit is clear sets no status.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset, used for both reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data at `reg_addr_i`, combinational |
| rd_done_i | input | 1 | Successful read transfer, one-cycle pulse |
| rd_bytes_i | input | 13 | Byte count of the read transfer |
| wr_done_i | input | 1 | Successful write transfer, one-cycle pulse |
| wr_bytes_i | input | 13 | Byte count of the write transfer |
| mabort_i | input | 1 | Master abort seen, one-cycle pulse |
| tabort_i | input | 1 | Target abort received, one-cycle pulse |
| cnt_off_i | input | 1 | Counter-off mode, level |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The assertions take for granted that completion and abort inputs are single-cycle pulses. They also take for granted that a completion pulse is never paired with a load of the same counter in the same cycle, since the load wins there and the no-wrap property would then compare against a new value. The bench drives each pulse for exactly one cycle from the falling edge and never overlaps a counter load with a completion. It overlaps a status clear with an abort only in the one vector that targets the set-over-clear rule.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam logic [ADDR_W-1:0] OFF_RD_CNT = 8'h30;
  localparam logic [ADDR_W-1:0] OFF_WR_CNT = 8'h34;
  localparam logic [ADDR_W-1:0] OFF_CSR    = 8'h38;
  localparam int unsigned BIT_EN_WR  = 14;
  localparam int unsigned BIT_EN_RD  = 15;
  localparam int unsigned BIT_ST_LO  = 18;
  localparam int unsigned N_STAT     = 4;
  // status vector order: 0 wr done, 1 rd done, 2 master abort, 3 target abort
  typedef enum logic [1:0] {ST_WR = 2'd0, ST_RD = 2'd1, ST_MAB = 2'd2, ST_TAB = 2'd3} stat_idx_e;
endpackage

// File: rtl/xfer_counter.sv
module xfer_counter #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BYTE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] bytes_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              zero_hit_o
);
  localparam int unsigned PAD_W = CNT_W - BYTE_W;

  logic [CNT_W-1:0] cnt_q, cnt_d, bytes_ext;
  logic             take_all;

  assign bytes_ext = {{PAD_W{1'b0}}, bytes_i};
  assign take_all  = bytes_ext >= cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)      cnt_d = load_val_i;
    else if (done_i) cnt_d = take_all ? '0 : cnt_q - bytes_ext;
  end

  // event only on a nonzero-to-zero step
  assign zero_hit_o = done_i & ~load_i & (cnt_q != '0) & take_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  p_no_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !load_i) |=> (cnt_q <= $past(cnt_q)));

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));

  p_hit_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_hit_o |=> (cnt_q == '0));
endmodule

// File: rtl/irq_status.sv
module irq_status #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic st_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       st_q <= 1'b0;
      else if (set_i[i]) st_q <= 1'b1;  // set beats clear
      else if (clr_i[i]) st_q <= 1'b0;
    end
    assign stat_o[i] = st_q;

    p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_q);
    p_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q && clr_i[i] && !set_i[i]) |=> !st_q);
    p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q && !clr_i[i]) |=> st_q);
  end
endmodule

// File: rtl/dma_cnt_irq.sv
module dma_cnt_irq
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BYTE_W = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  input  logic              rd_done_i,
  input  logic [BYTE_W-1:0] rd_bytes_i,
  input  logic              wr_done_i,
  input  logic [BYTE_W-1:0] wr_bytes_i,
  input  logic              mabort_i,
  input  logic              tabort_i,
  input  logic              cnt_off_i,
  output logic              irq_no
);
  localparam int unsigned ST_HI = BIT_ST_LO + N_STAT - 1;

  logic              csr_we, rd_ld, wr_ld;
  logic [CNT_W-1:0]  rd_cnt, wr_cnt;
  logic              rd_hit, wr_hit;
  logic              en_wr_q, en_rd_q, armed;
  logic [N_STAT-1:0] st_set, st_clr, stat;

  assign csr_we = reg_we_i && (reg_addr_i == OFF_CSR);
  assign rd_ld  = reg_we_i && (reg_addr_i == OFF_RD_CNT);
  assign wr_ld  = reg_we_i && (reg_addr_i == OFF_WR_CNT);

  xfer_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_rd_cnt (
    .clk_i, .rst_ni,
    .load_i(rd_ld), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .done_i(rd_done_i), .bytes_i(rd_bytes_i),
    .cnt_o(rd_cnt), .zero_hit_o(rd_hit)
  );

  xfer_counter #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_wr_cnt (
    .clk_i, .rst_ni,
    .load_i(wr_ld), .load_val_i(reg_wdata_i[CNT_W-1:0]),
    .done_i(wr_done_i), .bytes_i(wr_bytes_i),
    .cnt_o(wr_cnt), .zero_hit_o(wr_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_wr_q <= 1'b0;
      en_rd_q <= 1'b0;
    end else if (csr_we) begin
      en_wr_q <= reg_wdata_i[BIT_EN_WR];
      en_rd_q <= reg_wdata_i[BIT_EN_RD];
    end
  end

  // aborts have no own enable: armed by either count enable
  assign armed = en_wr_q | en_rd_q;

  always_comb begin
    st_set         = '0;
    st_set[ST_WR]  = wr_hit & en_wr_q & ~cnt_off_i;
    st_set[ST_RD]  = rd_hit & en_rd_q & ~cnt_off_i;
    st_set[ST_MAB] = mabort_i & armed;
    st_set[ST_TAB] = tabort_i & armed;
    st_clr         = csr_we ? reg_wdata_i[ST_HI:BIT_ST_LO] : '0;
  end

  irq_status #(.N(N_STAT)) u_stat (
    .clk_i, .rst_ni, .set_i(st_set), .clr_i(st_clr), .stat_o(stat)
  );

  assign irq_no = ~|stat;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_RD_CNT: reg_rdata_o[CNT_W-1:0] = rd_cnt;
      OFF_WR_CNT: reg_rdata_o[CNT_W-1:0] = wr_cnt;
      OFF_CSR: begin
        reg_rdata_o[BIT_EN_WR]          = en_wr_q;
        reg_rdata_o[BIT_EN_RD]          = en_rd_q;
        reg_rdata_o[ST_HI:BIT_ST_LO]    = stat;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  p_abort_irq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mabort_i || tabort_i) && armed) |=> !irq_no);

  p_unarmed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed && !stat[ST_MAB]) |=> !stat[ST_MAB]);

  p_cnt_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_off_i && !stat[ST_WR] && !stat[ST_RD]) |=> (!stat[ST_WR] && !stat[ST_RD]));

  p_gate_en_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_rd_q && !stat[ST_RD]) |=> !stat[ST_RD]);
endmodule

// File: tb/dma_cnt_irq_tb_top.sv
module dma_cnt_irq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  typedef enum logic [3:0] {
    OP_WR = 4'd0, OP_RD = 4'd1, OP_IRQ = 4'd2, OP_RDONE = 4'd3, OP_WDONE = 4'd4,
    OP_MAB = 4'd5, OP_TAB = 4'd6, OP_OFF = 4'd7, OP_WRMAB = 4'd8
  } op_e;

  typedef struct packed {
    op_e         op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 44;
  localparam vec_t VECS [NV] = '{
    '{OP_RD,   8'h38, 32'h0,        32'h0,        8'd1},  // R1
    '{OP_RD,   8'h30, 32'h0,        32'h0,        8'd1},  // R1
    '{OP_RD,   8'h34, 32'h0,        32'h0,        8'd1},  // R1
    '{OP_IRQ,  8'h00, 32'h0,        32'h1,        8'd1},  // R1
    '{OP_WR,   8'h38, 32'hFFFF_FFFF,32'h0,        8'd11}, // R11
    '{OP_RD,   8'h38, 32'h0,        32'h0000_C000,8'd11}, // R11
    '{OP_WR,   8'h38, 32'h0000_4000,32'h0,        8'd4},
    '{OP_WR,   8'h34, 32'd100,      32'h0,        8'd2},
    '{OP_RD,   8'h34, 32'h0,        32'd100,      8'd2},  // R2
    '{OP_WDONE,8'h00, 32'd30,       32'h0,        8'd3},
    '{OP_RD,   8'h34, 32'h0,        32'd70,       8'd3},  // R3
    '{OP_IRQ,  8'h00, 32'h0,        32'h1,        8'd8},  // R8
    '{OP_WDONE,8'h00, 32'd200,      32'h0,        8'd3},
    '{OP_RD,   8'h34, 32'h0,        32'd0,        8'd3},  // R3 saturate
    '{OP_RD,   8'h38, 32'h0,        32'h0004_4000,8'd4},  // R4
    '{OP_IRQ,  8'h00, 32'h0,        32'h0,        8'd8},  // R8
    '{OP_WR,   8'h38, 32'h0004_4000,32'h0,        8'd7},
    '{OP_WDONE,8'h00, 32'd5,        32'h0,        8'd5},
    '{OP_RD,   8'h38, 32'h0,        32'h0000_4000,8'd5},  // R5
    '{OP_IRQ,  8'h00, 32'h0,        32'h1,        8'd5},  // R5
    '{OP_WR,   8'h30, 32'd10,       32'h0,        8'd2},
    '{OP_RD,   8'h30, 32'h0,        32'd10,       8'd2},  // R2
    '{OP_RDONE,8'h00, 32'd10,       32'h0,        8'd12},
    '{OP_RD,   8'h38, 32'h0,        32'h0000_4000,8'd12}, // R12
    '{OP_WR,   8'h38, 32'h0000_C000,32'h0,        8'd4},
    '{OP_WR,   8'h30, 32'd8,        32'h0,        8'd4},
    '{OP_RDONE,8'h00, 32'd8,        32'h0,        8'd4},
    '{OP_RD,   8'h38, 32'h0,        32'h0008_C000,8'd4},  // R4
    '{OP_WR,   8'h38, 32'h0000_C000,32'h0,        8'd7},
    '{OP_RD,   8'h38, 32'h0,        32'h0008_C000,8'd7},  // R7 write zero
    '{OP_WR,   8'h38, 32'h0008_C000,32'h0,        8'd7},
    '{OP_RD,   8'h38, 32'h0,        32'h0000_C000,8'd7},  // R7 clear
    '{OP_MAB,  8'h00, 32'h0,        32'h0,        8'd6},
    '{OP_TAB,  8'h00, 32'h0,        32'h0,        8'd6},
    '{OP_RD,   8'h38, 32'h0,        32'h0030_C000,8'd6},  // R6
    '{OP_WR,   8'h38, 32'h0010_C000,32'h0,        8'd8},
    '{OP_IRQ,  8'h00, 32'h0,        32'h0,        8'd8},  // R8 one still pending
    '{OP_WR,   8'h38, 32'h0020_C000,32'h0,        8'd8},
    '{OP_IRQ,  8'h00, 32'h0,        32'h1,        8'd8},  // R8
    '{OP_WR,   8'h38, 32'h0,        32'h0,        8'd6},
    '{OP_MAB,  8'h00, 32'h0,        32'h0,        8'd6},
    '{OP_TAB,  8'h00, 32'h0,        32'h0,        8'd6},
    '{OP_RD,   8'h38, 32'h0,        32'h0,        8'd6},  // R6 unarmed
    '{OP_IRQ,  8'h00, 32'h0,        32'h1,        8'd6}   // R6
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        rd_done_i = 1'b0, wr_done_i = 1'b0;
  logic [12:0] rd_bytes_i = '0, wr_bytes_i = '0;
  logic        mabort_i = 1'b0, tabort_i = 1'b0, cnt_off_i = 1'b0;
  logic        irq_no;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dma_cnt_irq dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .rd_done_i, .rd_bytes_i, .wr_done_i, .wr_bytes_i,
    .mabort_i, .tabort_i, .cnt_off_i, .irq_no
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk_i);
    case (v.op)
      OP_WR:    begin reg_we_i = 1'b1; reg_addr_i = v.addr; reg_wdata_i = v.data; end
      OP_RDONE: begin rd_done_i = 1'b1; rd_bytes_i = v.data[12:0]; end
      OP_WDONE: begin wr_done_i = 1'b1; wr_bytes_i = v.data[12:0]; end
      OP_MAB:   mabort_i = 1'b1;
      OP_TAB:   tabort_i = 1'b1;
      OP_OFF:   cnt_off_i = v.data[0];
      OP_WRMAB: begin reg_we_i = 1'b1; reg_addr_i = v.addr; reg_wdata_i = v.data; mabort_i = 1'b1; end
      OP_RD:    begin reg_addr_i = v.addr; #1 check(reg_rdata_o, v.exp, int'(v.req)); end
      OP_IRQ:   begin #1 check({31'b0, irq_no}, v.exp, int'(v.req)); end
      default:  ;
    endcase
    @(negedge clk_i);
    reg_we_i = 1'b0; rd_done_i = 1'b0; wr_done_i = 1'b0; mabort_i = 1'b0; tabort_i = 1'b0;
  endtask

  function automatic vec_t mk(op_e op, logic [7:0] a, logic [31:0] d, logic [31:0] e, int r);
    return '{op, a, d, e, 8'(r)};
  endfunction

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk_i);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R9: counter-off mode inhibits count status
    run_vec(mk(OP_WR, 8'h38, 32'h0000_4000, 0, 9));
    run_vec(mk(OP_OFF, 8'h00, 32'h1, 0, 9));
    run_vec(mk(OP_WR, 8'h34, 32'd4, 0, 9));
    run_vec(mk(OP_WDONE, 8'h00, 32'd4, 0, 9));
    run_vec(mk(OP_RD, 8'h38, 0, 32'h0000_4000, 9));
    run_vec(mk(OP_IRQ, 8'h00, 0, 32'h1, 9));
    run_vec(mk(OP_OFF, 8'h00, 32'h0, 0, 9));

    // R10: set and clear of the same bit in one cycle
    run_vec(mk(OP_MAB, 8'h00, 0, 0, 10));
    run_vec(mk(OP_WRMAB, 8'h38, 32'h0010_4000, 0, 10));
    run_vec(mk(OP_RD, 8'h38, 0, 32'h0010_4000, 10));
    run_vec(mk(OP_WR, 8'h38, 32'h0010_4000, 0, 10));
    run_vec(mk(OP_RD, 8'h38, 0, 32'h0000_4000, 10));

    // R3: largest byte count onto a small counter
    run_vec(mk(OP_WR, 8'h34, 32'd1, 0, 3));
    run_vec(mk(OP_WDONE, 8'h00, 32'h1FFF, 0, 3));
    run_vec(mk(OP_RD, 8'h34, 0, 32'd0, 3));
    run_vec(mk(OP_RD, 8'h38, 0, 32'h0004_4000, 4));

    // R1: reset in mid-run with status pending
    run_vec(mk(OP_WR, 8'h30, 32'd55, 0, 1));
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    run_vec(mk(OP_RD, 8'h38, 0, 32'h0, 1));
    run_vec(mk(OP_RD, 8'h30, 0, 32'h0, 1));
    run_vec(mk(OP_IRQ, 8'h00, 0, 32'h1, 1));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule